// File: doc/BRIEF.md
# Display Strip Sequencer

This block sets the vertical layout of an on-screen display overlay. The screen is not a fixed text grid. It is a linked run of horizontal strips, and each strip is described by a two-byte descriptor in a 1 KB display RAM. A strip is one of two kinds:
- a spacing strip, which is a run of empty lines;
- a character strip, which points at a row of character codes in the same RAM.

A falling edge on vertical sync restarts the walk at the base of the selected page. The block then reads one descriptor after another, in order. Each per-line strobe either moves the current strip on by one scan line or starts the fetch of the next descriptor. The descriptor fetch shares the RAM read port with host accesses and takes that port for exactly two cycles.

Downstream pixel logic uses the outputs for every scan line:
- the strip kind;
- whether characters are displayed;
- whether the overlay must force black;
- the zoom flag;
- the even start address of the character codes;
- the scan-line index within the strip.

Top module: `strip_seq`

## Requirements
- R1: While reset is held, every strip output is 0, and the RAM port is in host pass-through: `ram_re_o` equals `host_req_i`, `ram_addr_o` equals `host_addr_i`, and `host_gnt_o` equals `host_req_i`.
- R2: A falling edge of `vsync_i` is a high level on one clock edge followed by a low level on the next. It has these effects:
  - It cancels any fetch in progress.
  - It loads the descriptor pointer with `page_i` shifted left by 6, with all other pointer bits zero.
  - It clears `strip_valid_o` and every other strip output to 0 from the next cycle.
  - They stay at 0 until a descriptor has been loaded.
  
  A rising edge of `vsync_i` has no effect.
- R3: After a restart, the first `line_i` strobe starts a fetch. A strobe on the last line of the current strip also starts a fetch. The fetch runs over the following cycles:
  - First cycle after the strobe edge: it reads the even address (the pointer).
  - Second cycle: it reads the odd address.
  - The RAM returns data one cycle after the address.
  - The new strip's outputs take effect at the third clock edge after the strobe edge, with a line index of 0.
  
  Any other strobe while a strip is valid advances the line index by one. Strobes received before the first restart are ignored.
- R4: Bit 7 of the even descriptor byte selects the strip kind: 0 is spacing, 1 is character. A spacing strip lasts as many scan lines as the odd byte gives, and a count of 0 is taken as 1. The other bits of a spacing descriptor's even byte are ignored.
- R5: In a character descriptor, the even byte's fields are:
  - bit 6: display enable;
  - bit 4: zoom;
  - bits 1:0: code address bits 9:8.
  
  Bits 7:1 of the odd byte give code address bits 7:1. Code address bit 0 is always 0.
- R6: A character strip lasts `char_h_i`×(1+zoom) scan lines. `char_h_i` is sampled when the descriptor loads, and 0 is taken as 1. With zoom set, `row_o` is the elapsed line count halved, so that each slice is shown on two lines. Otherwise `row_o` is the elapsed line count.
- R7: `disp_en_o` is 1 only for a valid character strip with display enable set. `fblk_force_o` equals `fbk_i` whenever a strip is valid and `disp_en_o` is 0, and is 0 otherwise.
- R8: Each loaded descriptor moves the pointer on by 2. The pointer wraps within 10 bits, so the descriptor after address 1022 is fetched from address 0.
- R9: During the two fetch read cycles, the RAM address comes from the sequencer and `host_gnt_o` is 0. In every other cycle, `host_addr_i` passes to `ram_addr_o`, `ram_re_o` equals `host_req_i`, and `host_gnt_o` equals `host_req_i`.
- R10: A vertical-sync fall during a fetch cancels that fetch, and no descriptor loads from it. A `line_i` strobe that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync level (falling edge restarts) |
| line_i | input | 1 | One-cycle strobe at the start of each line's blanking |
| page_i | input | 3 | Page select; table base = page_i << 6 |
| char_h_i | input | 6 | Character strip height in scan lines |
| fbk_i | input | 1 | Force black outside displayed characters |
| host_req_i | input | 1 | Host read request for the RAM port |
| host_addr_i | input | 10 | Host RAM address |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| host_gnt_o | output | 1 | Host owns the RAM port this cycle |
| ram_re_o | output | 1 | RAM read enable |
| ram_addr_o | output | 10 | RAM address |
| strip_valid_o | output | 1 | A strip is active |
| strip_char_o | output | 1 | Active strip is a character strip |
| disp_en_o | output | 1 | Characters are displayed on this line |
| zoom_o | output | 1 | Active character strip is zoomed |
| fblk_force_o | output | 1 | Force fast blanking for the whole line |
| code_addr_o | output | 10 | Even start address of the strip's character codes |
| row_o | output | 8 | Scan-line index within the strip (slice index for character strips) |

## Verification
The assertions check the following on every cycle:
- the even-then-odd order of the two fetch reads;
- host pass-through whenever the host is granted;
- the pointer step of 2 on each load;
- the clearing of the strip outputs after a vertical-sync fall;
- that `disp_en_o` never appears without a character strip.

Other behaviour needs the bench's scenarios:
- decoding of real descriptor bytes, including junk bits and an odd low byte;
- the length of each strip under zoom and heights of 0;
- page switching;
- a vertical-sync fall in the middle of a fetch;
- the pointer wrap past address 1022.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  localparam int DESC_BYTES = 2;

  typedef enum logic [1:0] {
    F_IDLE,
    F_EVEN,
    F_ODD,
    F_LOAD
  } fetch_st_e;
endpackage

// File: rtl/strip_desc_fetch.sv
module strip_desc_fetch
  import strip_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              host_gnt_o,
  output logic              busy_o,
  output logic              load_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  fetch_st_e         st_q;
  logic              fetch_rd;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE;
      hi_q <= '0;
    end else if (abort_i) begin
      st_q <= F_IDLE;
    end else begin
      unique case (st_q)
        F_IDLE: if (start_i) st_q <= F_EVEN;
        F_EVEN: st_q <= F_ODD;
        F_ODD: begin
          st_q <= F_LOAD;
          hi_q <= rdata_i;  // even byte returns while the odd one is addressed
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    fetch_rd = (st_q == F_EVEN) || (st_q == F_ODD);
    unique case (st_q)
      F_EVEN:  ram_addr_o = ptr_i;
      F_ODD:   ram_addr_o = ptr_i | ADDR_W'(1);
      default: ram_addr_o = host_addr_i;
    endcase
    ram_re_o   = fetch_rd | host_req_i;
    host_gnt_o = host_req_i & ~fetch_rd;
    busy_o     = st_q != F_IDLE;
    load_o     = (st_q == F_LOAD) & ~abort_i;
    hi_o       = hi_q;
    lo_o       = rdata_i;
  end

  p_even_then_odd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_EVEN && !abort_i) |=> (st_q == F_ODD && ram_addr_o[0] && ram_re_o));

  p_host_passthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> (ram_re_o && ram_addr_o == host_addr_i));

  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !load_o);
endmodule

// File: rtl/strip_line_ctr.sv
module strip_line_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             adv_i,
  input  logic             zy_i,
  output logic             last_o,
  output logic [CNT_W-1:0] row_o
);
  logic [CNT_W-1:0] cnt_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      total_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      total_q <= '0;
    end else if (load_i) begin
      cnt_q   <= '0;
      total_q <= total_i;
    end else if (adv_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    last_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, total_q};
    row_o  = zy_i ? (cnt_q >> 1) : cnt_q;
  end

  p_cnt_below_total_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_q != '0) |-> (cnt_q < total_q));
endmodule

// File: rtl/strip_seq.sv
module strip_seq
  import strip_seq_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int PAGE_W = 3,
  parameter  int CH_W   = 6,
  parameter  int CNT_W  = 8,
  localparam int ADDR_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              line_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CH_W-1:0]   char_h_i,
  input  logic              fbk_i,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              host_gnt_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              strip_valid_o,
  output logic              strip_char_o,
  output logic              disp_en_o,
  output logic              zoom_o,
  output logic              fblk_force_o,
  output logic [ADDR_W-1:0] code_addr_o,
  output logic [CNT_W-1:0]  row_o
);
  localparam int PAGE_SH = ADDR_W - PAGE_W - 1;

  logic              vs_q, vs_fall, need_q, valid_q;
  logic              busy, load, last, start, adv;
  logic [ADDR_W-1:0] ptr_q, page_base;
  logic [DATA_W-1:0] d_hi, d_lo;
  logic              cur_char_q, cur_de_q, cur_zy_q;
  logic [ADDR_W-1:0] cur_code_q;
  logic              n_char, n_de, n_zy;
  logic [ADDR_W-1:0] n_code;
  logic [CNT_W-1:0]  n_total;
  logic [CH_W-1:0]   ch_eff;

  always_comb begin
    vs_fall   = vs_q & ~vsync_i;
    page_base = ADDR_W'(page_i) << PAGE_SH;
    n_char    = d_hi[DATA_W-1];
    n_de      = n_char & d_hi[DATA_W-2];
    n_zy      = n_char & d_hi[DATA_W-4];
    n_code    = n_char ? {d_hi[1:0], d_lo[DATA_W-1:1], 1'b0} : '0;
    ch_eff    = (char_h_i == '0) ? CH_W'(1) : char_h_i;
    if (n_char) n_total = CNT_W'(ch_eff) << n_zy;
    else        n_total = (d_lo == '0) ? CNT_W'(1) : CNT_W'(d_lo);
    start = line_i & ~busy & ~vs_fall & (need_q | (valid_q & last));
    adv   = line_i & ~busy & ~vs_fall & valid_q & ~last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q       <= 1'b0;
      need_q     <= 1'b0;
      valid_q    <= 1'b0;
      ptr_q      <= '0;
      cur_char_q <= 1'b0;
      cur_de_q   <= 1'b0;
      cur_zy_q   <= 1'b0;
      cur_code_q <= '0;
    end else begin
      vs_q <= vsync_i;
      if (vs_fall) begin
        ptr_q      <= page_base;
        need_q     <= 1'b1;
        valid_q    <= 1'b0;
        cur_char_q <= 1'b0;
        cur_de_q   <= 1'b0;
        cur_zy_q   <= 1'b0;
        cur_code_q <= '0;
      end else begin
        if (start) need_q <= 1'b0;
        if (load) begin
          valid_q    <= 1'b1;
          ptr_q      <= ptr_q + ADDR_W'(DESC_BYTES);
          cur_char_q <= n_char;
          cur_de_q   <= n_de;
          cur_zy_q   <= n_zy;
          cur_code_q <= n_code;
        end
      end
    end
  end

  strip_desc_fetch #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (vs_fall),
    .ptr_i      (ptr_q),
    .host_req_i (host_req_i),
    .host_addr_i(host_addr_i),
    .rdata_i    (ram_rdata_i),
    .ram_re_o   (ram_re_o),
    .ram_addr_o (ram_addr_o),
    .host_gnt_o (host_gnt_o),
    .busy_o     (busy),
    .load_o     (load),
    .hi_o       (d_hi),
    .lo_o       (d_lo)
  );

  strip_line_ctr #(
    .CNT_W(CNT_W)
  ) i_line_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vs_fall),
    .load_i (load),
    .total_i(n_total),
    .adv_i  (adv),
    .zy_i   (cur_zy_q),
    .last_o (last),
    .row_o  (row_o)
  );

  always_comb begin
    strip_valid_o = valid_q;
    strip_char_o  = cur_char_q;
    disp_en_o     = cur_de_q;
    zoom_o        = cur_zy_q;
    code_addr_o   = cur_code_q;
    fblk_force_o  = valid_q & ~cur_de_q & fbk_i;
  end

  p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall |=> (!strip_valid_o && !strip_char_o && code_addr_o == '0));

  p_ptr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(DESC_BYTES))));

  p_en_needs_char_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_o |-> (strip_char_o && strip_valid_o));

  p_code_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o |-> !code_addr_o[0]);
endmodule

// File: tb/test_strip_seq.sv
module test_strip_seq;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vsync, line, fbk, host_req;
  logic [2:0] page;
  logic [5:0] ch;
  logic [9:0] host_addr, ram_addr, code_addr;
  logic [7:0] ram_rdata, row;
  logic       host_gnt, ram_re, s_valid, s_char, disp_en, zoom, fblk;
  logic [7:0] mem [0:1023];

  int checks = 0, errors = 0, phase = 0, wrap_hits = 0;
  bit done = 0;

  // model state
  int m_ptr, m_fcnt, m_cnt, m_total;
  bit m_vs_q, m_need, m_valid, m_char, m_de, m_zy;
  int m_code;

  always #(CLK_PER/2) clk = ~clk;

  strip_seq i_strip_seq (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .line_i(line), .page_i(page),
    .char_h_i(ch), .fbk_i(fbk), .host_req_i(host_req), .host_addr_i(host_addr),
    .ram_rdata_i(ram_rdata), .host_gnt_o(host_gnt), .ram_re_o(ram_re),
    .ram_addr_o(ram_addr), .strip_valid_o(s_valid), .strip_char_o(s_char),
    .disp_en_o(disp_en), .zoom_o(zoom), .fblk_force_o(fblk),
    .code_addr_o(code_addr), .row_o(row)
  );

  always @(posedge clk) if (ram_re) ram_rdata <= mem[ram_addr];

  always @(negedge clk) begin
    host_req  = ($urandom_range(0, 3) != 0);
    host_addr = 10'($urandom);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_vs_q = 0; m_need = 0; m_valid = 0; m_ptr = 0; m_fcnt = 0;
      m_char = 0; m_de = 0; m_zy = 0; m_code = 0; m_cnt = 0; m_total = 0;
    end else begin
      bit fall;
      fall = m_vs_q && !vsync;
      m_vs_q = vsync;
      if (fall) begin
        m_fcnt = 0; m_ptr = page * 64; m_need = 1; m_valid = 0;
        m_char = 0; m_de = 0; m_zy = 0; m_code = 0; m_cnt = 0; m_total = 0;
      end else if (m_fcnt == 3) begin
        int hi, lo, h;
        hi = mem[m_ptr]; lo = mem[m_ptr + 1];
        m_char = hi[7];
        m_de = m_char && hi[6];
        m_zy = m_char && hi[4];
        m_code = m_char ? ((hi % 4) * 256 + (lo / 2) * 2) : 0;
        h = (ch == 0) ? 1 : ch;
        if (m_char) m_total = m_zy ? 2 * h : h;
        else m_total = (lo == 0) ? 1 : lo;
        m_ptr = (m_ptr + 2) % 1024;
        m_cnt = 0; m_valid = 1; m_fcnt = 0;
      end else if (m_fcnt > 0) begin
        m_fcnt++;
      end else if (line) begin
        if (m_need || (m_valid && m_cnt + 1 >= m_total)) begin
          m_fcnt = 1; m_need = 0;
        end else if (m_valid) m_cnt++;
      end
    end
    #(CLK_PER/4);
    begin
      bit frd;
      frd = (m_fcnt == 1) || (m_fcnt == 2);
      chk("R2 R3 strip_valid", s_valid, m_valid);
      chk("R4 strip_char", s_char, m_char);
      chk("R5 code_addr", code_addr, m_code);
      chk("R6 row", row, m_zy ? m_cnt / 2 : m_cnt);
      chk("R6 zoom", zoom, m_zy);
      chk("R7 disp_en", disp_en, m_de);
      chk("R7 fblk_force", fblk, m_valid && !m_de && fbk);
      chk("R9 ram_re", ram_re, frd || host_req);
      chk("R9 host_gnt", host_gnt, host_req && !frd);
      chk("R8 R9 ram_addr", ram_addr,
          (m_fcnt == 1) ? m_ptr : (m_fcnt == 2) ? m_ptr + 1 : host_addr);
      if (phase == 4 && ram_re && !host_gnt && ram_addr == 0) wrap_hits++;
    end
  end

  task automatic strobe(input int gap);
    @(negedge clk) line = 1;
    @(negedge clk) line = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic vfall();
    @(negedge clk) vsync = 1;
    repeat (3) @(negedge clk);
    vsync = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i % 2) ? 8'h01 : 8'h00;
    // page 0
    mem[0] = 8'h00; mem[1] = 8'h03;   // spacing 3
    mem[2] = 8'hC2; mem[3] = 8'h57;   // char DE, code 0x256
    mem[4] = 8'hD1; mem[5] = 8'h20;   // char DE ZY, code 0x120
    mem[6] = 8'h80; mem[7] = 8'h10;   // char no DE
    mem[8] = 8'h00; mem[9] = 8'h00;   // spacing count 0 -> 1
    mem[10] = 8'h7F; mem[11] = 8'h02; // spacing with junk bits
    // page 5
    mem[320] = 8'hC0; mem[321] = 8'h00;
    mem[322] = 8'h00; mem[323] = 8'h04;
    mem[324] = 8'h92; mem[325] = 8'hFF; // char no DE, ZY, code 0x2FE

    rst_n = 0; vsync = 0; line = 0; page = 0; ch = 6'd5; fbk = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset valid", s_valid, 0);
    chk("R1 reset code", code_addr, 0);
    chk("R1 reset row", row, 0);
    chk("R1 reset gnt", host_gnt, host_req);
    chk("R1 reset addr", ram_addr, host_addr);
    @(negedge clk) rst_n = 1;

    phase = 1;
    repeat (3) strobe(4);          // no restart yet: ignored
    chk("R3 idle before restart", s_valid, 0);

    vfall();
    for (int i = 0; i < 40; i++) begin
      fbk = (i % 7) < 3;
      strobe(4);
    end

    phase = 2;
    ch = 6'd0; page = 3'd5;
    vfall();
    for (int i = 0; i < 6; i++) strobe(4);
    ch = 6'd2;
    for (int i = 0; i < 20; i++) strobe((i % 3 == 0) ? 1 : 4);

    phase = 3;
    page = 3'd0;
    @(negedge clk) vsync = 1;
    repeat (2) @(negedge clk);
    line = 1;
    @(negedge clk) line = 0; vsync = 0;
    repeat (4) @(negedge clk);
    #1 chk("R10 abort leaves no strip", s_valid, 0);
    strobe(4);
    #1 chk("R10 refetch after abort", s_valid, 1);
    for (int i = 0; i < 5; i++) strobe(4);

    phase = 4;
    page = 3'd7; ch = 6'd3;
    vfall();
    for (int i = 0; i < 300; i++) strobe(3);
    chk("R8 wrap fetch at 0", wrap_hits > 0, 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule